// File: doc/BRIEF.md
# Banked System Control Register File

This block holds the system control registers of a multithreaded processor core. A register is named by a 5-bit register number and a 3-bit select, which together form an 8-bit flat index. Each implemented register is a 32-bit value paired with a fixed 32-bit writable-bit mask. Each register is stored once, once per thread context, or once per processing element. Accesses carry the thread id of the requester, and that id picks the copy.

Software writes pass through the register's mask, so bits outside the mask keep their value. A separate direct-write port stores all 32 bits and is used by hardware that updates status fields or loads configuration. Reads are combinational. For per-element registers the copy is picked by the element number held in the low four bits of the requesting thread's bind register, so rebinding a thread changes which copy it sees.

Top module: `sysreg_file`

## Requirements
- R1: A software write to an implemented register stores (wdata & mask) | (old & ~mask) into the selected copy on the next clock edge.
- R2: The flat index is regnum*8 + sel. Implemented indices are: tlb_index 0, tlb_rand 8, elem_ctl 9, elem_cfg0 10, tlb_lo0 16, thr_status 17, thr_bind 18, tlb_lo1 24, tlb_ctx 32, tlb_pgmask 40, bad_vaddr 64, status 96, irq_ctl 97, shadow_ctl 98, cause 104, proc_id 120, excp_base 121, cfg0 128, cfg1 129, cfg3 131, ll_addr 136, dbg_ctl 184. Any other index reads 0, and writes to it through either port change nothing.
- R3: status, thr_status, thr_bind, ll_addr and dbg_ctl have one copy per thread context, selected directly by the thread id.
- R4: elem_ctl, elem_cfg0 and excp_base have one copy per processing element. The copy is the value of bits [3:0] of the requesting thread's thr_bind, or copy 0 when that value is not below NUM_PE.
- R5: All other implemented registers have one copy, which every thread id reaches.
- R6: Write masks: status 0xFF78FF17, cause 0x08C00300, tlb_index 0x7FFFFFFF, tlb_lo0 and tlb_lo1 0x3FFFFFFF, tlb_ctx 0xFF800000, tlb_pgmask 0x1FFFF800, excp_base 0x3FFFF000, cfg0 0x7FFF0007, irq_ctl 0x000003E0, shadow_ctl 0x0000F3C0.
- R7: proc_id, cfg1, cfg3, tlb_rand, bad_vaddr and ll_addr have an all-zero mask, so software writes leave them unchanged.
- R8: After reset: status is 0x00400004 (bit 22 and bit 2 set), tlb_rand is 63, excp_base is 0x80000000, cfg0 is 0x80000000, thr_bind copy t holds t<<21, every other copy is 0.
- R9: elem_ctl, elem_cfg0, thr_status, thr_bind and dbg_ctl have an all-ones mask.
- R10: A direct write stores all 32 bits, whatever the mask. When both ports write the same copy in one cycle, the direct write wins; when they target different copies, both take effect.
- R11: Reads are combinational: a write becomes visible on the read port only after the clock edge that stores it, and the old value is read before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_we | input | 1 | Software write enable |
| sw_tid | input | TID_W | Thread id of the software write |
| sw_regnum | input | 5 | Register number of the software write |
| sw_sel | input | 3 | Select of the software write |
| sw_wdata | input | 32 | Software write data |
| hw_we | input | 1 | Direct write enable |
| hw_tid | input | TID_W | Thread id of the direct write |
| hw_regnum | input | 5 | Register number of the direct write |
| hw_sel | input | 3 | Select of the direct write |
| hw_wdata | input | 32 | Direct write data |
| rd_tid | input | TID_W | Thread id of the read |
| rd_regnum | input | 5 | Register number of the read |
| rd_sel | input | 3 | Select of the read |
| rd_data | output | 32 | Read data of the selected copy |

## Verification
Every implemented register is written from each thread with all ones, all zeros and the two alternating patterns 0xA5A5A5A5 and 0x5A5A5A5A. After each write all copies are read back from both threads. The all-ones and all-zeros writes expose the mask, the alternating patterns catch swapped or shifted mask bits, and reading the other thread's copy shows whether the register is shared or banked. All 256 indices are probed to separate implemented indices from unimplemented ones. Directed cases rebind a thread to another element and to an out-of-range element, collide both write ports on one copy and on two copies, and compare reads just before and just after a write edge.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int DATA_W       = 32;
  localparam int REGNUM_W     = 5;
  localparam int SEL_W        = 3;
  localparam int IDX_W        = REGNUM_W + SEL_W;
  localparam int NSLOT        = 22;
  localparam int SLOT_W       = $clog2(NSLOT);
  localparam int PE_FIELD_W   = 4;
  localparam int BIND_SLOT    = 6;
  localparam int BIND_TC_LSB  = 21;

  typedef enum logic [1:0] {
    BANK_SHARED = 2'd0,
    BANK_TC     = 2'd1,
    BANK_PE     = 2'd2
  } bank_e;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    bank_e             bank;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] rst;
  } slot_desc_t;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
    bank_e             bank;
  } lookup_t;

  // Storage slot table: flat index, banking, writable mask, reset value.
  function automatic slot_desc_t slot_desc(input int s);
    slot_desc_t d;
    d = '{idx: '0, bank: BANK_SHARED, mask: '0, rst: '0};
    case (s)
      0:  d = '{idx: 8'd0,   bank: BANK_SHARED, mask: 32'h7FFF_FFFF, rst: 32'h0};
      1:  d = '{idx: 8'd8,   bank: BANK_SHARED, mask: 32'h0,         rst: 32'd63};
      2:  d = '{idx: 8'd9,   bank: BANK_PE,     mask: 32'hFFFF_FFFF, rst: 32'h0};
      3:  d = '{idx: 8'd10,  bank: BANK_PE,     mask: 32'hFFFF_FFFF, rst: 32'h0};
      4:  d = '{idx: 8'd16,  bank: BANK_SHARED, mask: 32'h3FFF_FFFF, rst: 32'h0};
      5:  d = '{idx: 8'd17,  bank: BANK_TC,     mask: 32'hFFFF_FFFF, rst: 32'h0};
      6:  d = '{idx: 8'd18,  bank: BANK_TC,     mask: 32'hFFFF_FFFF, rst: 32'h0};
      7:  d = '{idx: 8'd24,  bank: BANK_SHARED, mask: 32'h3FFF_FFFF, rst: 32'h0};
      8:  d = '{idx: 8'd32,  bank: BANK_SHARED, mask: 32'hFF80_0000, rst: 32'h0};
      9:  d = '{idx: 8'd40,  bank: BANK_SHARED, mask: 32'h1FFF_F800, rst: 32'h0};
      10: d = '{idx: 8'd64,  bank: BANK_SHARED, mask: 32'h0,         rst: 32'h0};
      11: d = '{idx: 8'd96,  bank: BANK_TC,     mask: 32'hFF78_FF17, rst: 32'h0040_0004};
      12: d = '{idx: 8'd97,  bank: BANK_SHARED, mask: 32'h0000_03E0, rst: 32'h0};
      13: d = '{idx: 8'd98,  bank: BANK_SHARED, mask: 32'h0000_F3C0, rst: 32'h0};
      14: d = '{idx: 8'd104, bank: BANK_SHARED, mask: 32'h08C0_0300, rst: 32'h0};
      15: d = '{idx: 8'd120, bank: BANK_SHARED, mask: 32'h0,         rst: 32'h0};
      16: d = '{idx: 8'd121, bank: BANK_PE,     mask: 32'h3FFF_F000, rst: 32'h8000_0000};
      17: d = '{idx: 8'd128, bank: BANK_SHARED, mask: 32'h7FFF_0007, rst: 32'h8000_0000};
      18: d = '{idx: 8'd129, bank: BANK_SHARED, mask: 32'h0,         rst: 32'h0};
      19: d = '{idx: 8'd131, bank: BANK_SHARED, mask: 32'h0,         rst: 32'h0};
      20: d = '{idx: 8'd136, bank: BANK_TC,     mask: 32'h0,         rst: 32'h0};
      21: d = '{idx: 8'd184, bank: BANK_TC,     mask: 32'hFFFF_FFFF, rst: 32'h0};
      default: d = '{idx: '0, bank: BANK_SHARED, mask: '0, rst: '0};
    endcase
    return d;
  endfunction

  function automatic bank_e slot_bank(input int s);
    slot_desc_t d;
    d = slot_desc(s);
    return d.bank;
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(input int s);
    slot_desc_t d;
    d = slot_desc(s);
    return d.mask;
  endfunction

  function automatic logic [DATA_W-1:0] slot_rst(input int s);
    slot_desc_t d;
    d = slot_desc(s);
    return d.rst;
  endfunction

  function automatic lookup_t lookup(input logic [IDX_W-1:0] idx);
    lookup_t    r;
    slot_desc_t d;
    r = '{hit: 1'b0, slot: '0, bank: BANK_SHARED};
    for (int s = 0; s < NSLOT; s++) begin
      d = slot_desc(s);
      if (d.idx == idx) begin
        r.hit  = 1'b1;
        r.slot = SLOT_W'(s);
        r.bank = d.bank;
      end
    end
    return r;
  endfunction

  function automatic int copies_of(input bank_e b, input int n_tc, input int n_pe);
    case (b)
      BANK_TC: return n_tc;
      BANK_PE: return n_pe;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sysreg_bank_sel.sv
module sysreg_bank_sel
  import sysreg_pkg::*;
#(
  parameter int NUM_TC = 2,
  parameter int NUM_PE = 2,
  parameter int TID_W  = 1,
  parameter int CPY_W  = 1
) (
  input  logic [TID_W-1:0]      tid,
  input  bank_e                 bank,
  input  logic [PE_FIELD_W-1:0] pe_field [NUM_TC],
  output logic [CPY_W-1:0]      copy,
  output logic                  ok
);

  logic [TID_W-1:0]      tid_safe;
  logic [PE_FIELD_W-1:0] pe_num;
  logic                  pe_in_range;

  always_comb begin
    ok          = (32'(tid) < 32'(NUM_TC));
    tid_safe    = ok ? tid : '0;
    pe_num      = pe_field[tid_safe];
    pe_in_range = (32'(pe_num) < 32'(NUM_PE));
    case (bank)
      BANK_TC: copy = CPY_W'(tid_safe);
      BANK_PE: copy = pe_in_range ? CPY_W'(pe_num) : '0;
      default: copy = '0;
    endcase
  end

  // R4: the resolved copy always names an existing copy of the bank kind
  always_comb begin
    if (ok) begin
      p_copy_in_range_r4: assert (32'(copy) < 32'(copies_of(bank, NUM_TC, NUM_PE)));
    end
  end

endmodule

// File: rtl/sysreg_cell.sv
module sysreg_cell #(
  parameter int               DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK  = '1,
  parameter logic [DATA_W-1:0] RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_hit,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              hw_hit,
  input  logic [DATA_W-1:0] hw_wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    merged = (sw_wdata & MASK) | (q & ~MASK);
    q_nxt  = hw_hit ? hw_wdata : merged;
    q_en   = hw_hit | sw_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (q_en) q <= q_nxt;
  end

  // R1: protected bits survive a software write
  p_sw_keeps_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && !hw_hit) |=> ((q & ~MASK) == ($past(q) & ~MASK)));

  // R1: writable bits follow the software data
  p_sw_takes_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && !hw_hit) |=> ((q & MASK) == ($past(sw_wdata) & MASK)));

  // R10: direct write stores the full word and wins over software
  p_hw_full_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_hit |=> (q == $past(hw_wdata)));

  // R11: without a write the copy holds
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_hit && !hw_hit) |=> $stable(q));

endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter int NUM_TC = 2,
  parameter int NUM_PE = 2,
  parameter int TID_W  = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_we,
  input  logic [TID_W-1:0]    sw_tid,
  input  logic [REGNUM_W-1:0] sw_regnum,
  input  logic [SEL_W-1:0]    sw_sel,
  input  logic [DATA_W-1:0]   sw_wdata,
  input  logic                hw_we,
  input  logic [TID_W-1:0]    hw_tid,
  input  logic [REGNUM_W-1:0] hw_regnum,
  input  logic [SEL_W-1:0]    hw_sel,
  input  logic [DATA_W-1:0]   hw_wdata,
  input  logic [TID_W-1:0]    rd_tid,
  input  logic [REGNUM_W-1:0] rd_regnum,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [DATA_W-1:0]   rd_data
);

  localparam int MAXC  = (NUM_TC > NUM_PE) ? NUM_TC : NUM_PE;
  localparam int CPY_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // index decode for the three access paths
  lookup_t sw_lk, hw_lk, rd_lk;
  always_comb begin
    sw_lk = lookup({sw_regnum, sw_sel});
    hw_lk = lookup({hw_regnum, hw_sel});
    rd_lk = lookup({rd_regnum, rd_sel});
  end

  logic [DATA_W-1:0]     cell_q   [NSLOT][MAXC];
  logic [PE_FIELD_W-1:0] pe_field [NUM_TC];

  for (genvar t = 0; t < NUM_TC; t++) begin : g_bind
    assign pe_field[t] = cell_q[BIND_SLOT][t][PE_FIELD_W-1:0];
  end

  logic [CPY_W-1:0] sw_copy, hw_copy, rd_copy;
  logic             sw_ok, hw_ok, rd_ok;

  sysreg_bank_sel #(.NUM_TC(NUM_TC), .NUM_PE(NUM_PE), .TID_W(TID_W), .CPY_W(CPY_W)) u_sw_sel (
    .tid(sw_tid), .bank(sw_lk.bank), .pe_field(pe_field), .copy(sw_copy), .ok(sw_ok));

  sysreg_bank_sel #(.NUM_TC(NUM_TC), .NUM_PE(NUM_PE), .TID_W(TID_W), .CPY_W(CPY_W)) u_hw_sel (
    .tid(hw_tid), .bank(hw_lk.bank), .pe_field(pe_field), .copy(hw_copy), .ok(hw_ok));

  sysreg_bank_sel #(.NUM_TC(NUM_TC), .NUM_PE(NUM_PE), .TID_W(TID_W), .CPY_W(CPY_W)) u_rd_sel (
    .tid(rd_tid), .bank(rd_lk.bank), .pe_field(pe_field), .copy(rd_copy), .ok(rd_ok));

  logic sw_go, hw_go;
  assign sw_go = sw_we && sw_lk.hit && sw_ok;
  assign hw_go = hw_we && hw_lk.hit && hw_ok;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int               NC    = copies_of(slot_bank(s), NUM_TC, NUM_PE);
    localparam logic [DATA_W-1:0] MASKV = slot_mask(s);
    for (genvar c = 0; c < MAXC; c++) begin : g_copy
      if (c < NC) begin : g_cell
        localparam logic [DATA_W-1:0] RSTV = (s == BIND_SLOT)
                                           ? (slot_rst(s) | (DATA_W'(c) << BIND_TC_LSB))
                                           : slot_rst(s);
        logic sw_hit, hw_hit;
        assign sw_hit = sw_go && (sw_lk.slot == SLOT_W'(s)) && (sw_copy == CPY_W'(c));
        assign hw_hit = hw_go && (hw_lk.slot == SLOT_W'(s)) && (hw_copy == CPY_W'(c));

        sysreg_cell #(.DATA_W(DATA_W), .MASK(MASKV), .RST(RSTV)) u_cell (
          .clk      (clk),
          .rst_n    (rst_core_n),
          .sw_hit   (sw_hit),
          .sw_wdata (sw_wdata),
          .hw_hit   (hw_hit),
          .hw_wdata (hw_wdata),
          .q        (cell_q[s][c])
        );
      end else begin : g_none
        assign cell_q[s][c] = '0;
      end
    end
  end

  always_comb begin
    if (rd_lk.hit && rd_ok) rd_data = cell_q[rd_lk.slot][rd_copy];
    else                    rd_data = '0;
  end

endmodule

// File: tb/sysreg_file_tb.sv
module sysreg_file_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 22;
  localparam int NTC = 2;
  localparam int NPE = 2;

  logic        clk;
  logic        rst_n;
  logic        sw_we, hw_we;
  logic [0:0]  sw_tid, hw_tid, rd_tid;
  logic [4:0]  sw_regnum, hw_regnum, rd_regnum;
  logic [2:0]  sw_sel, hw_sel, rd_sel;
  logic [31:0] sw_wdata, hw_wdata, rd_data;

  sysreg_file #(.NUM_TC(NTC), .NUM_PE(NPE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_tid(sw_tid), .sw_regnum(sw_regnum), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .hw_we(hw_we), .hw_tid(hw_tid), .hw_regnum(hw_regnum), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
    .rd_tid(rd_tid), .rd_regnum(rd_regnum), .rd_sel(rd_sel), .rd_data(rd_data));

  int n_checks = 0;
  int n_fail   = 0;

  // bench-side model built from the requirements
  int          b_idx  [NS];
  int          b_bank [NS];   // 0 shared, 1 per thread, 2 per element
  logic [31:0] b_mask [NS];
  logic [31:0] b_rst  [NS];
  logic [31:0] m      [NS][2];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic set_desc(input int s, input int idx, input int bank,
                          input logic [31:0] mask, input logic [31:0] rst);
    b_idx[s] = idx; b_bank[s] = bank; b_mask[s] = mask; b_rst[s] = rst;
  endtask

  task automatic init_model();
    set_desc(0, 0, 0, 32'h7FFF_FFFF, 32'h0);
    set_desc(1, 8, 0, 32'h0, 32'd63);
    set_desc(2, 9, 2, 32'hFFFF_FFFF, 32'h0);
    set_desc(3, 10, 2, 32'hFFFF_FFFF, 32'h0);
    set_desc(4, 16, 0, 32'h3FFF_FFFF, 32'h0);
    set_desc(5, 17, 1, 32'hFFFF_FFFF, 32'h0);
    set_desc(6, 18, 1, 32'hFFFF_FFFF, 32'h0);
    set_desc(7, 24, 0, 32'h3FFF_FFFF, 32'h0);
    set_desc(8, 32, 0, 32'hFF80_0000, 32'h0);
    set_desc(9, 40, 0, 32'h1FFF_F800, 32'h0);
    set_desc(10, 64, 0, 32'h0, 32'h0);
    set_desc(11, 96, 1, 32'hFF78_FF17, 32'h0040_0004);
    set_desc(12, 97, 0, 32'h0000_03E0, 32'h0);
    set_desc(13, 98, 0, 32'h0000_F3C0, 32'h0);
    set_desc(14, 104, 0, 32'h08C0_0300, 32'h0);
    set_desc(15, 120, 0, 32'h0, 32'h0);
    set_desc(16, 121, 2, 32'h3FFF_F000, 32'h8000_0000);
    set_desc(17, 128, 0, 32'h7FFF_0007, 32'h8000_0000);
    set_desc(18, 129, 0, 32'h0, 32'h0);
    set_desc(19, 131, 0, 32'h0, 32'h0);
    set_desc(20, 136, 1, 32'h0, 32'h0);
    set_desc(21, 184, 1, 32'hFFFF_FFFF, 32'h0);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < 2; c++)
        m[s][c] = b_rst[s] | ((s == 6) ? (32'(c) << 21) : 32'h0);
  endtask

  function automatic int slot_of(input int idx);
    for (int s = 0; s < NS; s++) if (b_idx[s] == idx) return s;
    return -1;
  endfunction

  function automatic int copy_of(input int s, input int tid);
    int f;
    if (b_bank[s] == 1) return tid;
    if (b_bank[s] == 2) begin
      f = int'(m[6][tid] & 32'hF);
      return (f < NPE) ? f : 0;
    end
    return 0;
  endfunction

  function automatic string bank_tag(input int s);
    if (b_bank[s] == 1) return "R3";
    if (b_bank[s] == 2) return "R4";
    return "R5";
  endfunction

  task automatic check_read(input int tid, input int idx, input logic [31:0] exp,
                            input string tag);
    rd_tid = 1'(tid); {rd_regnum, rd_sel} = 8'(idx);
    #1;
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s idx=%0d tid=%0d got=%h exp=%h", tag, idx, tid, rd_data, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int t = 0; t < NTC; t++)
      for (int s = 0; s < NS; s++)
        check_read(t, b_idx[s], m[s][copy_of(s, t)], {tag, " ", bank_tag(s)});
  endtask

  task automatic cycle(input bit swe, input int swt, input int swi, input logic [31:0] swd,
                       input bit hwe, input int hwt, input int hwi, input logic [31:0] hwd);
    int ss, hs, sc, hc;
    @(negedge clk);
    sw_we = swe; sw_tid = 1'(swt); {sw_regnum, sw_sel} = 8'(swi); sw_wdata = swd;
    hw_we = hwe; hw_tid = 1'(hwt); {hw_regnum, hw_sel} = 8'(hwi); hw_wdata = hwd;
    ss = slot_of(swi); hs = slot_of(hwi);
    sc = (ss >= 0) ? copy_of(ss, swt) : 0;
    hc = (hs >= 0) ? copy_of(hs, hwt) : 0;
    @(negedge clk);
    sw_we = 1'b0; hw_we = 1'b0;
    if (swe && ss >= 0) m[ss][sc] = (swd & b_mask[ss]) | (m[ss][sc] & ~b_mask[ss]);
    if (hwe && hs >= 0) m[hs][hc] = hwd;
  endtask

  task automatic sw_write(input int t, input int idx, input logic [31:0] d);
    cycle(1'b1, t, idx, d, 1'b0, 0, 0, 32'h0);
  endtask

  task automatic hw_write(input int t, input int idx, input logic [31:0] d);
    cycle(1'b0, 0, 0, 32'h0, 1'b1, t, idx, d);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] old_v;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;

    rst_n = 1'b0; sw_we = 1'b0; hw_we = 1'b0;
    sw_tid = '0; hw_tid = '0; rd_tid = '0;
    sw_regnum = '0; hw_regnum = '0; rd_regnum = '0;
    sw_sel = '0; hw_sel = '0; rd_sel = '0;
    sw_wdata = '0; hw_wdata = '0;
    init_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state, R9 default masks shown by later sweep
    check_all("R8 reset");

    // R2: unimplemented indices read 0 and ignore writes on both ports
    for (int i = 0; i < 256; i++) begin
      if (slot_of(i) < 0) begin
        cycle(1'b1, 0, i, 32'hFFFF_FFFF, 1'b1, 1, i, 32'hFFFF_FFFF);
        check_read(0, i, 32'h0, "R2 unimplemented");
        check_read(1, i, 32'h0, "R2 unimplemented");
      end
    end
    check_all("R2 after stray writes");

    // R1 R6 R7 R9: masked write sweep over all registers, threads, patterns
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < NS; s++)
        for (int t = 0; t < NTC; t++) begin
          sw_write(t, b_idx[s], pats[p]);
          check_all("R1 R6 R7 R9 sweep");
        end

    // R4: bind thread 1 to element 1, element copies diverge
    hw_write(1, 18, 32'h0000_0001);
    sw_write(0, 9, 32'h1111_1111);
    sw_write(1, 9, 32'h2222_2222);
    sw_write(1, 121, 32'hFFFF_FFFF);
    check_all("R4 rebind");
    check_read(0, 9, 32'h1111_1111, "R4 element0 copy");
    check_read(1, 9, 32'h2222_2222, "R4 element1 copy");

    // R4: out-of-range element number falls back to copy 0
    hw_write(1, 18, 32'h0000_0007);
    sw_write(1, 9, 32'h3333_3333);
    check_read(0, 9, 32'h3333_3333, "R4 clamp");
    check_all("R4 clamp");

    // R10: both ports on one copy, direct write wins
    cycle(1'b1, 0, 104, 32'hFFFF_FFFF, 1'b1, 0, 104, 32'h1234_5678);
    check_read(0, 104, 32'h1234_5678, "R10 same copy");
    // R10: both ports on different copies, both land
    cycle(1'b1, 1, 96, 32'hFFFF_FFFF, 1'b1, 0, 96, 32'hCAFE_F00D);
    check_read(0, 96, 32'hCAFE_F00D, "R10 direct copy");
    check_read(1, 96, 32'hFF78_FF17 | m[11][1], "R10 software copy");
    // R10 R7: direct write reaches a software-locked register
    hw_write(0, 8, 32'hDEAD_BEEF);
    check_read(1, 8, 32'hDEAD_BEEF, "R10 R7 locked direct");
    check_all("R10 final");

    // R11: old value before the edge, new value after it
    old_v = m[0][0];
    @(negedge clk);
    sw_we = 1'b1; sw_tid = 1'b0; {sw_regnum, sw_sel} = 8'd0; sw_wdata = 32'h0F0F_0F0F;
    check_read(0, 0, old_v, "R11 before edge");
    @(negedge clk);
    sw_we = 1'b0;
    m[0][0] = 32'h0F0F_0F0F;
    check_read(0, 0, 32'h0F0F_0F0F, "R11 after edge");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule